// File: doc/BRIEF.md
# Hart Halt Summary and Group Control Hub

This block sits in a debug module and keeps track of which harts are halted, for up to 1024 harts. Each hart's halted flag is sampled into a status bit. The status bits are packed 32 to a word in a read-only window. A summary word above them has one bit per group of 32 harts, so a debugger can find halted harts without reading every status word.

The block drives one halt-request line and one resume-request line to each hart. A command written to the control register reaches the hart chosen by a select index. When group mode is set, the command instead reaches every hart whose arm bit is set, all in the same cycle. A request line stays high until the hart acknowledges the request. A halt request is acknowledged when the hart reports halted. A resume request is acknowledged when the hart reports running. A hart that is executing debug program-buffer code keeps reporting halted, and the block shows it as halted.

Register access goes through a simple word-addressed port. Writes take effect at the clock edge. Reads are combinational from registered state.

Top module: `hart_halt_hub`

## Requirements
- R1: After reset, all halt-request and resume-request lines are low, every arm word reads zero, and the summary word reads zero.
- R2: Status word w sits at word address 0x40+w. Bit b of that word is the halted flag of hart 32w+b, and it reflects the hart's halted input one cycle after the input changes. Bits and words for harts at or beyond the hart count read zero.
- R3: The summary word sits at word address 0x11. Bit g is set exactly when at least one hart in group g (harts 32g to 32g+31) shows halted in the status words.
- R4: The control register sits at word address 0x10, with these fields: bit 0 = halt command, bit 1 = resume command, bit 2 = group mode, bits 25:16 = hart select index. The select index and the group-mode bit are stored and read back. Bits 0 and 1 read as zero.
- R5: With group mode clear, a halt or resume command raises the request line of the selected hart only. A select index at or beyond the hart count raises no line.
- R6: A halt-request line stays high while its hart reports not halted. It drops in the cycle after the hart reports halted.
- R7: A resume-request line stays high while its hart reports not running. It drops in the cycle after the hart reports running.
- R8: If bits 0 and 1 are both set in one control write, only the halt command takes effect.
- R9: Arm word w sits at word address 0x20+w and is readable and writable. Arm bits for harts at or beyond the hart count read zero, and writes to them are ignored.
- R10: With group mode set, a halt or resume command raises the request line of every armed hart in the same cycle, and of no other hart.
- R11: Writes to the status words and to the summary word have no effect.
- R12: A new halt command to a hart clears that hart's pending resume request, and a new resume command clears its pending halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 7 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| hartHalted | input | NUM_HARTS | Per-hart halted report |
| hartRunning | input | NUM_HARTS | Per-hart running report |
| haltReqO | output | NUM_HARTS | Per-hart halt-request lines |
| resumeReqO | output | NUM_HARTS | Per-hart resume-request lines |

## Verification
The bench holds acknowledgements back so that it can see request lines stay high. It then releases them and checks that each line drops in exactly the next cycle; a design that cleared on the write, or a cycle late, would miss that sample. The bench uses a hart count that is not a multiple of 32 and aims writes at the upper arm bits, at an arm word past the end, and at select indices beyond the last hart; a design without range guards would read those bits back or raise a stray line. It also sends both command bits at once and sends conflicting commands to one hart. A design without halt priority or without cross-cancelling would drive both lines to the same hart.

// File: rtl/hhub_pkg.sv
package hhub_pkg;

  localparam int unsigned SEL_W = 10;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] CTRL_ADDR    = 7'h10;
  localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 7'h11;
  localparam logic [1:0]        ARM_WIN      = 2'b01;  // 0x20..0x3f
  localparam logic [1:0]        STAT_WIN     = 2'b10;  // 0x40..0x5f

  typedef struct packed {
    logic             haltGo;
    logic             resumeGo;
    logic             useArm;
    logic [SEL_W-1:0] sel;
    logic             armWr;
    logic [4:0]       armWord;
  } strobe_t;

endpackage

// File: rtl/hhub_ctrl.sv
module hhub_ctrl
  import hhub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [2:0]        cmdBits,
  input  logic [SEL_W-1:0]  selBits,
  output strobe_t           str,
  output logic [31:0]       ctrlRdWord
);

  logic             ctrlWr;
  logic [SEL_W-1:0] selQ;
  logic             useArmQ;

  assign ctrlWr = regWrEn && (regAddr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= '0;
      useArmQ <= 1'b0;
    end else if (ctrlWr) begin
      selQ    <= selBits;
      useArmQ <= cmdBits[2];
    end
  end

  always_comb begin
    str          = '0;
    str.haltGo   = ctrlWr && cmdBits[0];
    str.resumeGo = ctrlWr && cmdBits[1] && !cmdBits[0];
    str.useArm   = cmdBits[2];
    str.sel      = selBits;
    str.armWr    = regWrEn && (regAddr[6:5] == ARM_WIN);
    str.armWord  = regAddr[4:0];
  end

  assign ctrlRdWord = {6'b0, selQ, 13'b0, useArmQ, 2'b00};

  // R8
  halt_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == CTRL_ADDR && cmdBits[0]) |-> (str.haltGo && !str.resumeGo));

  // R4
  sel_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == CTRL_ADDR) |=> (ctrlRdWord[25:16] == $past(selBits)));

endmodule

// File: rtl/hhub_data.sv
module hhub_data
  import hhub_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              str,
  input  logic [31:0]          wrData,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          ctrlRdWord,
  input  logic [NUM_HARTS-1:0] hartHalted,
  input  logic [NUM_HARTS-1:0] hartRunning,
  output logic [NUM_HARTS-1:0] haltReqO,
  output logic [NUM_HARTS-1:0] resumeReqO,
  output logic [31:0]          regRdData
);

  localparam int unsigned NUM_WORDS = (NUM_HARTS + 31) / 32;
  localparam int unsigned PAD_BITS  = NUM_WORDS * 32;

  logic [NUM_HARTS-1:0] armQ, haltedQ, haltReqQ, resumeReqQ;
  logic [NUM_HARTS-1:0] target, haltSet, resSet;
  logic [PAD_BITS-1:0]  armPad, armPadNext, haltedPad, selPad;
  logic [31:0]          summary;

  // one-hot from select index, guarded against out-of-range
  always_comb begin
    selPad = '0;
    if ({{(32-SEL_W){1'b0}}, str.sel} < 32'(NUM_HARTS)) selPad[str.sel] = 1'b1;
  end

  assign target  = str.useArm ? armQ : selPad[NUM_HARTS-1:0];
  assign haltSet = str.haltGo   ? target : '0;
  assign resSet  = str.resumeGo ? target : '0;

  always_comb begin
    armPad = '0;
    armPad[NUM_HARTS-1:0] = armQ;
    haltedPad = '0;
    haltedPad[NUM_HARTS-1:0] = haltedQ;
    armPadNext = armPad;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (str.armWr && str.armWord == 5'(w)) armPadNext[w*32 +: 32] = wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ       <= '0;
      haltedQ    <= '0;
      haltReqQ   <= '0;
      resumeReqQ <= '0;
    end else begin
      armQ       <= armPadNext[NUM_HARTS-1:0];
      haltedQ    <= hartHalted;
      haltReqQ   <= (haltReqQ & ~hartHalted & ~resSet) | haltSet;
      resumeReqQ <= (resumeReqQ & ~hartRunning & ~haltSet) | resSet;
    end
  end

  generate
    for (genvar g = 0; g < 32; g++) begin : g_sum
      if (g < int'(NUM_WORDS)) begin : g_live
        assign summary[g] = |haltedPad[g*32 +: 32];
      end else begin : g_pad
        assign summary[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_ADDR) begin
      regRdData = ctrlRdWord;
    end else if (regAddr == SUMMARY_ADDR) begin
      regRdData = summary;
    end else begin
      for (int w = 0; w < int'(NUM_WORDS); w++) begin
        if (regAddr[4:0] == 5'(w)) begin
          if (regAddr[6:5] == ARM_WIN)  regRdData = armPad[w*32 +: 32];
          if (regAddr[6:5] == STAT_WIN) regRdData = haltedPad[w*32 +: 32];
        end
      end
    end
  end

  assign haltReqO   = haltReqQ;
  assign resumeReqO = resumeReqQ;

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((haltReqQ & ~hartHalted & ~resSet) != '0) |=>
      (($past(haltReqQ & ~hartHalted & ~resSet) & ~haltReqQ) == '0));

  // R6
  halt_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((haltReqQ & hartHalted & ~haltSet) != '0) |=>
      (($past(haltReqQ & hartHalted & ~haltSet) & haltReqQ) == '0));

  // R7
  resume_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((resumeReqQ & ~hartRunning & ~haltSet) != '0) |=>
      (($past(resumeReqQ & ~hartRunning & ~haltSet) & ~resumeReqQ) == '0));

  // R12
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((haltReqQ & resumeReqQ) == '0));

  // R3
  summary_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((summary != '0) == (haltedQ != '0)));

endmodule

// File: rtl/hart_halt_hub.sv
module hart_halt_hub
  import hhub_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [6:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_HARTS-1:0] hartHalted,
  input  logic [NUM_HARTS-1:0] hartRunning,
  output logic [NUM_HARTS-1:0] haltReqO,
  output logic [NUM_HARTS-1:0] resumeReqO
);

  strobe_t     str;
  logic [31:0] ctrlRdWord;

  hhub_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .cmdBits   (regWrData[2:0]),
    .selBits   (regWrData[25:16]),
    .str       (str),
    .ctrlRdWord(ctrlRdWord)
  );

  hhub_data #(.NUM_HARTS(NUM_HARTS)) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .str        (str),
    .wrData     (regWrData),
    .regAddr    (regAddr),
    .ctrlRdWord (ctrlRdWord),
    .hartHalted (hartHalted),
    .hartRunning(hartRunning),
    .haltReqO   (haltReqO),
    .resumeReqO (resumeReqO),
    .regRdData  (regRdData)
  );

endmodule

// File: tb/hart_halt_hub_tb_top.sv
module hart_halt_hub_tb_top;

  localparam int N = 48;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [6:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [N-1:0]  hartHalted = '0;
  logic [N-1:0]  hartRunning;
  logic [N-1:0]  haltReqO, resumeReqO;

  int total = 0;
  int fails = 0;

  assign hartRunning = ~hartHalted;

  always #2.5 clk = ~clk;

  hart_halt_hub #(.NUM_HARTS(N)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hartHalted(hartHalted),
    .hartRunning(hartRunning), .haltReqO(haltReqO), .resumeReqO(resumeReqO)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlWord(int sel, bit halt, bit res, bit grp);
    return {6'b0, 10'(sel), 13'b0, grp, res, halt};
  endfunction

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic tResetState();
    logic [31:0] d;
    chk("R1 halt lines", 64'(haltReqO), 64'h0);
    chk("R1 resume lines", 64'(resumeReqO), 64'h0);
    rd(7'h20, d); chk("R1 arm word0", 64'(d), 64'h0);
    rd(7'h11, d); chk("R1 summary", 64'(d), 64'h0);
  endtask

  task automatic tSingleHalt();
    logic [31:0] d;
    wr(7'h10, ctrlWord(5, 1, 0, 0));
    chk("R5 single halt", 64'(haltReqO), 64'h1 << 5);
    rd(7'h10, d); chk("R4 ctrl readback", 64'(d), 64'(ctrlWord(5, 0, 0, 0)));
    repeat (3) @(negedge clk);
    chk("R6 halt held", 64'(haltReqO), 64'h1 << 5);
    hartHalted[5] = 1'b1;
    @(negedge clk);
    chk("R6 halt dropped", 64'(haltReqO), 64'h0);
    rd(7'h40, d); chk("R2 status word0", 64'(d), 64'h20);
    rd(7'h11, d); chk("R3 summary one group", 64'(d), 64'h1);
  endtask

  task automatic tSingleResume();
    wr(7'h10, ctrlWord(5, 0, 1, 0));
    chk("R5 single resume", 64'(resumeReqO), 64'h1 << 5);
    repeat (2) @(negedge clk);
    chk("R7 resume held", 64'(resumeReqO), 64'h1 << 5);
    hartHalted[5] = 1'b0;
    @(negedge clk);
    chk("R7 resume dropped", 64'(resumeReqO), 64'h0);
  endtask

  task automatic tPriority();
    wr(7'h10, ctrlWord(7, 1, 1, 0));
    chk("R8 halt wins", 64'(haltReqO), 64'h1 << 7);
    chk("R8 no resume", 64'(resumeReqO), 64'h0);
    hartHalted[7] = 1'b1;
    @(negedge clk);
    chk("R6 hart7 dropped", 64'(haltReqO), 64'h0);
  endtask

  task automatic tCancel();
    wr(7'h10, ctrlWord(9, 1, 0, 0));
    wr(7'h10, ctrlWord(9, 0, 1, 0));
    chk("R12 halt cancelled", 64'(haltReqO), 64'h0);
    chk("R12 resume raised", 64'(resumeReqO), 64'h1 << 9);
    @(negedge clk);
    chk("R7 running drops resume", 64'(resumeReqO), 64'h0);
  endtask

  task automatic tRange();
    logic [31:0] d;
    wr(7'h10, ctrlWord(48, 1, 0, 0));
    chk("R5 select out of range", 64'(haltReqO), 64'h0);
    wr(7'h10, ctrlWord(1023, 0, 1, 0));
    chk("R5 select max ignored", 64'(resumeReqO), 64'h0);
    wr(7'h21, 32'hFFFF_FFFF);
    rd(7'h21, d); chk("R9 arm upper bits", 64'(d), 64'h0000_FFFF);
    wr(7'h25, 32'hFFFF_FFFF);
    rd(7'h25, d); chk("R9 arm word past end", 64'(d), 64'h0);
    rd(7'h42, d); chk("R2 status word past end", 64'(d), 64'h0);
  endtask

  task automatic tGroup();
    logic [31:0] d;
    logic [63:0] mask = 64'h0000_8001_0000_0103;
    wr(7'h20, 32'h0000_0103);
    wr(7'h21, 32'h0000_8001);
    rd(7'h20, d); chk("R9 arm word0", 64'(d), 64'h103);
    rd(7'h21, d); chk("R9 arm word1", 64'(d), 64'h8001);
    wr(7'h10, ctrlWord(3, 1, 0, 1));
    chk("R10 group halt", 64'(haltReqO), mask);
    hartHalted = hartHalted | mask[N-1:0];
    @(negedge clk);
    chk("R6 group halt dropped", 64'(haltReqO), 64'h0);
    rd(7'h11, d); chk("R3 summary two groups", 64'(d), 64'h3);
    rd(7'h41, d); chk("R2 status word1", 64'(d), 64'h8001);
    wr(7'h10, ctrlWord(3, 0, 1, 1));
    chk("R10 group resume", 64'(resumeReqO), mask);
    hartHalted = hartHalted & ~mask[N-1:0];
    @(negedge clk);
    chk("R7 group resume dropped", 64'(resumeReqO), 64'h0);
  endtask

  task automatic tReadOnly();
    logic [31:0] d;
    wr(7'h40, 32'h0);
    rd(7'h40, d); chk("R11 status write ignored", 64'(d), 64'h80);
    wr(7'h11, 32'h0);
    rd(7'h11, d); chk("R11 summary write ignored", 64'(d), 64'h1);
    chk("R11 no request raised", 64'(haltReqO | resumeReqO), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tResetState();
    tSingleHalt();
    tSingleResume();
    tPriority();
    tCancel();
    tRange();
    tGroup();
    tReadOnly();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule